// File: doc/BRIEF.md
# Range CRC-16 Command Unit

The block executes one memory-check command. A five-word command arrives over a 16-bit word stream and names a 24-bit start address and a count of 24-bit memory locations. The block then walks the range through a synchronous read port and moves the address on by 2 per location. Each location's three bytes enter a CRC-16 engine one per clock. When the walk ends, the block returns the result as a three-word response frame.

A first word with the wrong opcode or length is rejected at once with a short failure frame. Command words that arrive while a command is being processed are dropped. The host therefore sends the next command only after it has seen the previous response.

Top module: `crc_range_unit`

## Requirements
- R1: The first word is a valid header only when bits 15:12 equal 0xC and bits 11:0 equal 5.
- R2: Field placement. Word 2 carries address bits 23:16 in its bits 7:0, and its bits 15:8 are ignored. Word 3 carries address bits 15:0. Word 4 carries count bits 23:16 in its bits 7:0. Word 5 carries count bits 15:0.
- R3: A count of N locations issues exactly N reads, at the start address plus 2k for k = 0..N-1, with 24-bit wrap. Read data is taken the cycle after `mem_rd_o` is high.
- R4: Each location feeds the CRC in the order of its bits 7:0, then 15:8, then 23:16.
- R5: The CRC starts at 0xFFFF, uses polynomial 0x1021, shifts each byte in MSB first, and applies neither reflection nor a final XOR. The bytes of "123456789" give 0x29B1.
- R6: A good command answers with three consecutive `rsp_valid_o` words: 0x1C00, then 0x0003, then the CRC.
- R7: A count of zero issues no read and returns 0xFFFF as the CRC.
- R8: A rejected header answers with two words, {0x2, received opcode, 0x00} and then 0x0002, and issues no read. The next accepted word is treated as a new header.
- R9: The first response word appears 3N+4 cycles after the cycle in which the fifth word is accepted when N>0, and 3 cycles after it when N=0. After a rejected header, the first response word appears 2 cycles later.
- R10: Command words from the cycle after the last frame word up to and including the last response word have no effect.
- R11: Bytes flow one per clock through a whole run. Each read after the first is issued in the cycle that delivers the previous location's last byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_word_i | input | 16 | Command word |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 24 | Memory read address |
| mem_data_i | input | 24 | Read data, valid the cycle after the request |
| rsp_valid_o | output | 1 | Response word strobe |
| rsp_word_o | output | 16 | Response word |

## Verification
For a run of N locations, the first response word is due 3N+4 cycles after the fifth command word is accepted, or 3 cycles after it when N is zero. A rejected header is answered 2 cycles after it is taken. The bench counts falling edges from the one that follows the accepting edge and checks the exact cycle on which `rsp_valid_o` rises. It then samples the remaining response words on the following falling edges. The bench memory model checks every read address in the same cycle the read is issued, so a stray or misplaced read is caught even when the CRC happens to match.

// File: rtl/crc_range_pkg.sv
package crc_range_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = 24;
  localparam int unsigned LOC_W    = 24;
  localparam int unsigned CNT_W    = 24;
  localparam int unsigned CRC_W    = 16;
  localparam int unsigned FRAME_N  = 5;
  localparam int unsigned IDX_W    = $clog2(FRAME_N);
  localparam logic [3:0]  OPC_CRC  = 4'hC;
  localparam logic [11:0] LEN_CRC  = 12'd5;
  localparam logic [3:0]  ST_PASS  = 4'h1;
  localparam logic [3:0]  ST_FAIL  = 4'h2;
  localparam logic [WORD_W-1:0] PASS_LEN = 16'h0003;
  localparam logic [WORD_W-1:0] FAIL_LEN = 16'h0002;
  localparam logic [ADDR_W-1:0] ADDR_STEP = 24'd2;

  typedef enum logic [2:0] {
    WK_IDLE, WK_RD, WK_B0, WK_B1, WK_B2, WK_FIN
  } walk_st_e;

  typedef enum logic [2:0] {
    RS_IDLE, RS_P0, RS_P1, RS_P2, RS_F0, RS_F1
  } rsp_st_e;
endpackage

// File: rtl/crc_cmd_parse.sv
module crc_cmd_parse
  import crc_range_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              start_o,
  output logic              reject_o,
  output logic [3:0]        reject_op_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [IDX_W-1:0]  idx_q;
  logic              start_q, reject_q;
  logic [3:0]        op_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  count_q;
  logic              hdr_ok;

  assign hdr_ok = (word_i[15:12] == OPC_CRC) && (word_i[11:0] == LEN_CRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      start_q  <= 1'b0;
      reject_q <= 1'b0;
      op_q     <= '0;
      base_q   <= '0;
      count_q  <= '0;
    end else begin
      start_q  <= 1'b0;
      reject_q <= 1'b0;
      if (word_valid_i) begin
        case (idx_q)
          IDX_W'(0): begin
            if (hdr_ok) idx_q <= IDX_W'(1);
            else begin
              reject_q <= 1'b1;
              op_q     <= word_i[15:12];
            end
          end
          IDX_W'(1): begin
            base_q[23:16] <= word_i[7:0];
            idx_q         <= IDX_W'(2);
          end
          IDX_W'(2): begin
            base_q[15:0] <= word_i;
            idx_q        <= IDX_W'(3);
          end
          IDX_W'(3): begin
            count_q[23:16] <= word_i[7:0];
            idx_q          <= IDX_W'(4);
          end
          default: begin
            count_q[15:0] <= word_i;
            start_q       <= 1'b1;
            idx_q         <= '0;
          end
        endcase
      end
    end
  end

  assign start_o     = start_q;
  assign reject_o    = reject_q;
  assign reject_op_o = op_q;
  assign base_o      = base_q;
  assign count_o     = count_q;

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_i |=> $stable(idx_q) && $stable(base_q) && $stable(count_q));
  a_r1_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && reject_o));
  a_r8_reject_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> idx_q == '0);
endmodule

// File: rtl/crc_mem_walker.sv
module crc_mem_walker
  import crc_range_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [LOC_W-1:0]  mem_data_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  output logic              done_o,
  output logic              busy_o
);
  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [LOC_W-9:0]  hold_q;
  logic              more;

  assign more = (left_q != '0);

  always_comb begin
    st_d         = st_q;
    mem_rd_o     = 1'b0;
    byte_valid_o = 1'b0;
    byte_o       = '0;
    done_o       = 1'b0;
    case (st_q)
      WK_IDLE: if (start_i) st_d = (count_i == '0) ? WK_FIN : WK_RD;
      WK_RD: begin
        mem_rd_o = 1'b1;
        st_d     = WK_B0;
      end
      WK_B0: begin
        byte_valid_o = 1'b1;
        byte_o       = mem_data_i[7:0];
        st_d         = WK_B1;
      end
      WK_B1: begin
        byte_valid_o = 1'b1;
        byte_o       = hold_q[7:0];
        st_d         = WK_B2;
      end
      WK_B2: begin
        byte_valid_o = 1'b1;
        byte_o       = hold_q[15:8];
        mem_rd_o     = more;  // overlap next fetch with last byte
        st_d         = more ? WK_B0 : WK_FIN;
      end
      WK_FIN: begin
        done_o = 1'b1;
        st_d   = WK_IDLE;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WK_IDLE;
      addr_q <= '0;
      left_q <= '0;
      hold_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == WK_IDLE && start_i) begin
        addr_q <= base_i;
        left_q <= count_i;
      end
      if (mem_rd_o) left_q <= left_q - CNT_W'(1);
      if (st_q == WK_B0) begin
        hold_q <= mem_data_i[LOC_W-1:8];
        addr_q <= addr_q + ADDR_STEP;
      end
    end
  end

  assign mem_addr_o = addr_q;
  assign busy_o     = (st_q != WK_IDLE);

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && $past(mem_rd_o, 3) |-> mem_addr_o == $past(mem_addr_o, 3) + ADDR_STEP);
  a_r3_read_feeds_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> byte_valid_o);
  a_r11_byte_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byte_valid_o) |=> byte_valid_o ##1 byte_valid_o);
  a_r7_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && count_i == '0 |=> done_o && !mem_rd_o);
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc_range_pkg::*;
#(
  parameter logic [CRC_W-1:0] INIT = 16'hFFFF,
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             valid_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0]      crc_q;
  logic [8:0][CRC_W-1:0] chain;

  assign chain[0] = crc_q;

  for (genvar g = 0; g < 8; g++) begin : g_bit
    logic fb;
    assign fb         = chain[g][CRC_W-1] ^ byte_i[7-g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (init_i)  crc_q <= INIT;
    else if (valid_i) crc_q <= chain[8];
  end

  assign crc_o = crc_q;

  a_r5_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> crc_o == INIT);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i && !valid_i |=> $stable(crc_o));
endmodule

// File: rtl/crc_rsp_seq.sv
module crc_rsp_seq
  import crc_range_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pass_i,
  input  logic [CRC_W-1:0]  crc_i,
  input  logic              fail_i,
  input  logic [3:0]        fail_op_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_word_o,
  output logic              busy_o
);
  rsp_st_e          st_q;
  logic [CRC_W-1:0] crc_q;
  logic [3:0]       op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RS_IDLE;
      crc_q <= '0;
      op_q  <= '0;
    end else begin
      case (st_q)
        RS_IDLE: begin
          if (pass_i) begin
            st_q  <= RS_P0;
            crc_q <= crc_i;
          end else if (fail_i) begin
            st_q <= RS_F0;
            op_q <= fail_op_i;
          end
        end
        RS_P0:   st_q <= RS_P1;
        RS_P1:   st_q <= RS_P2;
        RS_F0:   st_q <= RS_F1;
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  always_comb begin
    rsp_word_o = '0;
    case (st_q)
      RS_P0:   rsp_word_o = {ST_PASS, OPC_CRC, 8'h00};
      RS_P1:   rsp_word_o = PASS_LEN;
      RS_P2:   rsp_word_o = crc_q;
      RS_F0:   rsp_word_o = {ST_FAIL, op_q, 8'h00};
      RS_F1:   rsp_word_o = FAIL_LEN;
      default: rsp_word_o = '0;
    endcase
  end

  assign rsp_valid_o = (st_q != RS_IDLE);
  assign busy_o      = rsp_valid_o;

  a_r6_single_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_i, fail_i}));
  a_r6_pass_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i && !busy_o |=> rsp_valid_o ##1 rsp_valid_o ##1 rsp_valid_o);
endmodule

// File: rtl/crc_range_unit.sv
module crc_range_unit
  import crc_range_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [LOC_W-1:0]  mem_data_i,
  output logic              rsp_valid_o,
  output logic [WORD_W-1:0] rsp_word_o
);
  logic              start, reject, walk_busy, rsp_busy, engaged, word_take;
  logic [3:0]        reject_op;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  count;
  logic              byte_valid, walk_done;
  logic [7:0]        byte_val;
  logic [CRC_W-1:0]  crc;

  assign engaged   = start | reject | walk_busy | rsp_busy;
  assign word_take = cmd_valid_i & ~engaged;

  crc_cmd_parse u_parse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .word_valid_i(word_take),
    .word_i      (cmd_word_i),
    .start_o     (start),
    .reject_o    (reject),
    .reject_op_o (reject_op),
    .base_o      (base),
    .count_o     (count)
  );

  crc_mem_walker u_walk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .base_i      (base),
    .count_i     (count),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_i  (mem_data_i),
    .byte_valid_o(byte_valid),
    .byte_o      (byte_val),
    .done_o      (walk_done),
    .busy_o      (walk_busy)
  );

  crc16_engine #(.INIT(CRC_INIT), .POLY(CRC_POLY)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (start),
    .valid_i(byte_valid),
    .byte_i (byte_val),
    .crc_o  (crc)
  );

  crc_rsp_seq u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pass_i     (walk_done),
    .crc_i      (crc),
    .fail_i     (reject),
    .fail_op_i  (reject_op),
    .rsp_valid_o(rsp_valid_o),
    .rsp_word_o (rsp_word_o),
    .busy_o     (rsp_busy)
  );

  a_r6_pass_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_done |=> rsp_valid_o && rsp_word_o == 16'h1C00);
  a_r8_fail_header: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> rsp_valid_o && rsp_word_o[15:12] == 4'h2 && !mem_rd_o);
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> !walk_busy && !rsp_busy);
  a_r3_no_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> walk_busy);
endmodule

// File: tb/crc_range_unit_bench.sv
module crc_range_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [15:0] cmd_word_i = '0;
  logic        mem_rd_o;
  logic [23:0] mem_addr_o;
  logic [23:0] mem_data_i = '0;
  logic        rsp_valid_o;
  logic [15:0] rsp_word_o;

  int n_chk = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int rd_err = 0;
  int rd_start = 0;
  logic [23:0] exp_base = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crc_range_unit u_crc_range_unit (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_word_o(rsp_word_o)
  );

  function automatic logic [23:0] mem_fn(logic [23:0] a);
    if (a == 24'h100000) return {8'h33, 8'h32, 8'h31};
    if (a == 24'h100002) return {8'h36, 8'h35, 8'h34};
    if (a == 24'h100004) return {8'h39, 8'h38, 8'h37};
    return {a[7:0] ^ 8'hA5, a[15:8] + a[23:16], a[7:0] + 8'h3C};
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb = r[15] ^ b[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      mem_data_i <= mem_fn(mem_addr_o);
      if (mem_addr_o != exp_base + 24'(2 * (rd_cnt - rd_start))) rd_err <= rd_err + 1;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic send_word(logic [15:0] w);
    cmd_valid_i = 1'b1;
    cmd_word_i  = w;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  // returns cycles from the accepting edge to the first response word
  task automatic wait_rsp(int limit, bit junk, output int cyc);
    cyc = 1;
    while (!rsp_valid_o && cyc < limit) begin
      if (junk) begin
        cmd_valid_i = 1'b1;
        cmd_word_i  = 16'hC005;
      end
      @(negedge clk_i);
      cyc++;
    end
  endtask

  task automatic run_crc(logic [23:0] base, logic [23:0] n, logic [7:0] rsvd, bit junk, string tag);
    logic [15:0] exp_crc = 16'hFFFF;
    int cyc;
    int exp_cyc;
    logic [15:0] w0, w1, w2;
    for (int k = 0; k < int'(n); k++) begin
      logic [23:0] d = mem_fn(base + 24'(2 * k));
      exp_crc = crc_step(exp_crc, d[7:0]);
      exp_crc = crc_step(exp_crc, d[15:8]);
      exp_crc = crc_step(exp_crc, d[23:16]);
    end
    exp_base = base;
    rd_start = rd_cnt;
    rd_err   = 0;
    send_word(16'hC005);
    send_word({rsvd, base[23:16]});
    send_word(base[15:0]);
    send_word({8'h00, n[23:16]});
    send_word(n[15:0]);
    exp_cyc = (n == 0) ? 3 : 3 * int'(n) + 4;
    wait_rsp(exp_cyc + 20, junk, cyc);
    check({"R9 latency ", tag}, cyc, exp_cyc);
    w0 = rsp_word_o;
    @(negedge clk_i);
    w1 = rsp_word_o;
    check({"R6 valid w1 ", tag}, rsp_valid_o, 1);
    @(negedge clk_i);
    w2 = rsp_word_o;
    check({"R6 valid w2 ", tag}, rsp_valid_o, 1);
    cmd_valid_i = 1'b0;
    @(negedge clk_i);
    check({"R6 frame end ", tag}, rsp_valid_o, 0);
    check({"R6 header ", tag}, w0, 16'h1C00);
    check({"R6 length ", tag}, w1, 16'h0003);
    check({"R5 R4 crc ", tag}, w2, exp_crc);
    check({"R3 read count ", tag}, rd_cnt - rd_start, n);
    check({"R3 read addr ", tag}, rd_err, 0);
  endtask

  task automatic run_bad(logic [15:0] hdr, string tag);
    int cyc;
    logic [15:0] w0, w1;
    rd_start = rd_cnt;
    send_word(hdr);
    wait_rsp(30, 1'b0, cyc);
    check({"R9 reject latency ", tag}, cyc, 2);
    w0 = rsp_word_o;
    @(negedge clk_i);
    w1 = rsp_word_o;
    @(negedge clk_i);
    check({"R8 fail header ", tag}, w0, {4'h2, hdr[15:12], 8'h00});
    check({"R8 fail length ", tag}, w1, 16'h0002);
    check({"R8 frame end ", tag}, rsp_valid_o, 0);
    check({"R8 no read ", tag}, rd_cnt - rd_start, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("reset rsp_valid_o", rsp_valid_o, 0);
    check("reset mem_rd_o", mem_rd_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 R4: known ASCII vector
    run_crc(24'h100000, 24'd3, 8'h00, 1'b0, "ascii");
    // R7 zero count
    run_crc(24'h001234, 24'd0, 8'h00, 1'b0, "zero");
    // R2: reserved byte ignored, upper address byte used
    for (int s = 1; s <= 8; s++)
      run_crc(24'hA50000 + 24'(s * 64), 24'(s), 8'(s * 17), 1'b0, "sweep");
    // R3: address carry into upper byte and 24-bit wrap
    run_crc(24'h3CFFFC, 24'd4, 8'hFF, 1'b0, "carry");
    run_crc(24'hFFFFFC, 24'd3, 8'h00, 1'b0, "wrap");
    // R2: count upper byte (65537 locations)
    run_crc(24'h020000, 24'h010001, 8'h00, 1'b0, "bigcount");
    // R1 R8: every wrong opcode, then wrong lengths
    for (int op = 0; op < 16; op++)
      if (op != 12) run_bad({4'(op), 12'h005}, "opcode");
    run_bad(16'hC000, "len0");
    run_bad(16'hC004, "len4");
    run_bad(16'hC006, "len6");
    run_bad(16'hCFFF, "lenmax");
    // R8: word after reject is a fresh header
    run_crc(24'h100000, 24'd3, 8'h00, 1'b0, "after reject");
    // R10: header words while busy change nothing
    run_crc(24'h004400, 24'd5, 8'h00, 1'b1, "busy junk");
    run_crc(24'h000000, 24'd2, 8'h00, 1'b0, "after junk");
    // R11 covered by exact latency 3N+4 for the multi-location runs above

    summary();
    $finish;
  end
endmodule